// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Arithmetic Slice

This block is one arithmetic slice built around a 48-bit result register. A pre-adder can sum two 25-bit signed operands. The 25-bit value then feeds a 25 x 18 signed multiplier, and the product is sign-extended to 48 bits. The sign-extended product, or a raw 48-bit operand when the multiplier is bypassed, is the X operand of a 48-bit ALU. The ALU's second operand Z is zero, the result register itself, or a separate 48-bit operand. The ALU adds or subtracts as one 48-bit lane, two 24-bit lanes or four 12-bit lanes, or applies one of ten bitwise functions.

A masked comparator checks every ALU result against a fixed pattern and against its complement. Both flags are stored together with the result, which supports rounding schemes that need to spot particular low-order bit patterns. All operation codes are captured with their operands and travel through the pipeline with them, so the mode can change on every cycle. A single clock-enable freezes every stage. With the multiplier bypassed, an X operand of one and Z taken from the result register turns the slice into an up/down counter.

Top module: `mac_slice`

## Requirements
- R1: While `rst_n` is low, `p_out`, `carry_out`, `pat_hit` and `pat_hit_inv` are all zero.
- R2: With `mul_bypass`=0 and `pre_en`=0, X is the signed product `a_in` x `b_in`, sign-extended to 48 bits.
- R3: With `pre_en`=1, the multiplier's 25-bit operand is (`a_in` + `d_in`) wrapped to 25-bit two's complement.
- R4: With `mul_bypass`=1, X is `ab_in` unchanged.
- R5: `z_sel` picks Z: 0 gives zero, 1 gives the current `p_out`, 2 gives `c_in`, 3 gives zero. `alu_op` 0 (and 3) computes Z + X, and 1 computes Z - X.
- R6: With `z_sel`=1, successive results accumulate onto the previous `p_out`, modulo 2^48.
- R7: `simd_mode` 0 (and 3) is one 48-bit lane, 1 is two 24-bit lanes, and 2 is four 12-bit lanes. Lane k covers bits k*w upward. No carry crosses a lane boundary. A subtraction adds the inverted X with a carry-in of one in every lane. `carry_out[k]` is lane k's adder carry, and bits without a lane are zero.
- R8: `alu_op`=2 selects the logic unit, with A = X and B = Z. `logic_fn` codes are: 0 AND, 1 OR, 2 XOR, 3 XNOR, 4 NAND, 5 NOR, 6 A&~B, 7 ~A&B, 8 A|~B, 9 ~A|B. Codes 10-15 give zero. `carry_out` is zero in this mode.
- R9: `pat_hit` is 1 when (result XOR PATTERN) AND MASK is zero. `pat_hit_inv` is 1 when (result XOR ~PATTERN) AND MASK is zero. Both flags register together with the result.
- R10: Inputs sampled at an enabled edge reach the outputs after 1 + IN_REG + MUL_REG enabled edges, with their own opcodes. When `ce` is low, no stage changes.
- R11: With `mul_bypass`=1, `ab_in`=1, `z_sel`=1, a single lane and `alu_op` 0 or 1, `p_out` counts up or down by one on each enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for every stage |
| a_in | input | 25 | Signed multiplier operand, first pre-adder input |
| d_in | input | 25 | Signed second pre-adder input |
| b_in | input | 18 | Signed multiplier operand |
| ab_in | input | 48 | X operand when the multiplier is bypassed |
| c_in | input | 48 | Z operand when `z_sel`=2 |
| pre_en | input | 1 | Enable pre-adder |
| mul_bypass | input | 1 | Use `ab_in` instead of the product |
| z_sel | input | 2 | Z operand select |
| alu_op | input | 2 | Add, subtract or logic |
| simd_mode | input | 2 | Lane split |
| logic_fn | input | 4 | Logic function code |
| p_out | output | 48 | Registered result |
| carry_out | output | 4 | Per-lane carry |
| pat_hit | output | 1 | Masked pattern match |
| pat_hit_inv | output | 1 | Masked complement match |

## Verification
Accumulation feedback and a change of lane split can land in the same cycle. The result register is then being read as Z while the operation in flight splits it differently from the one before. The bench provokes this by switching `simd_mode` and `alu_op` on consecutive cycles while `z_sel` stays on feedback, with X values that carry across every 12-bit boundary. It judges each cycle against a queue-based model that redoes the lane arithmetic with plain integer widths and rebuilds the carries and both pattern flags on its own.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  localparam int P_W   = 48;
  localparam int SEG_W = 12;
  localparam int N_SEG = P_W / SEG_W;

  typedef enum logic [1:0] {SIMD_ONE = 2'd0, SIMD_TWO = 2'd1, SIMD_FOUR = 2'd2, SIMD_RSV = 2'd3} simd_e;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_LOGIC = 2'd2, OP_RSV = 2'd3} aluop_e;
  typedef enum logic [1:0] {Z_ZERO = 2'd0, Z_ACC = 2'd1, Z_C = 2'd2, Z_RSV = 2'd3} zsel_e;

  typedef struct packed {
    zsel_e      zsel;
    aluop_e     op;
    simd_e      simd;
    logic [3:0] fn;
  } alu_ctrl_t;

  typedef struct packed {
    logic      pre_en;
    logic      mul_bypass;
    alu_ctrl_t alu;
  } ctrl_t;

  typedef struct packed {
    logic [N_SEG-1:0] co;
    logic [P_W-1:0]   sum;
  } addres_t;

  // A segment opens a new lane (fresh carry-in)
  function automatic logic seg_opens_lane(simd_e m, int s);
    case (m)
      SIMD_TWO:  return (s % 2) == 0;
      SIMD_FOUR: return 1'b1;
      default:   return s == 0;
    endcase
  endfunction

  // Segmented adder: Z + X or Z - X per lane, carries mapped to lanes
  function automatic addres_t lane_addsub(logic [P_W-1:0] z, logic [P_W-1:0] x,
                                          logic sub, simd_e m);
    addres_t          r;
    logic             c;
    logic [SEG_W:0]   t;
    logic [N_SEG-1:0] seg_co;
    r = '0;
    c = 1'b0;
    seg_co = '0;
    for (int s = 0; s < N_SEG; s++) begin
      if (seg_opens_lane(m, s)) c = sub;
      t = {1'b0, z[s*SEG_W +: SEG_W]} + {1'b0, x[s*SEG_W +: SEG_W] ^ {SEG_W{sub}}}
          + {{SEG_W{1'b0}}, c};
      r.sum[s*SEG_W +: SEG_W] = t[SEG_W-1:0];
      c = t[SEG_W];
      seg_co[s] = c;
    end
    case (m)
      SIMD_TWO:  r.co = {2'b00, seg_co[3], seg_co[1]};
      SIMD_FOUR: r.co = seg_co;
      default:   r.co = {3'b000, seg_co[3]};
    endcase
    return r;
  endfunction

  function automatic logic [P_W-1:0] logic_unit(logic [P_W-1:0] a, logic [P_W-1:0] b,
                                                logic [3:0] fn);
    case (fn)
      4'd0:    return a & b;
      4'd1:    return a | b;
      4'd2:    return a ^ b;
      4'd3:    return ~(a ^ b);
      4'd4:    return ~(a & b);
      4'd5:    return ~(a | b);
      4'd6:    return a & ~b;
      4'd7:    return ~a & b;
      4'd8:    return a | ~b;
      4'd9:    return ~a | b;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mac_stage_reg.sv
module mac_stage_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic signed [A_W-1:0] a,
  input  logic signed [A_W-1:0] d,
  input  logic signed [B_W-1:0] b,
  input  logic                  pre_en,
  output logic        [P_W-1:0] prod
);
  localparam int M_W = A_W + B_W;
  logic signed [A_W-1:0] pre_sum;
  logic signed [M_W-1:0] m;
  always_comb begin
    pre_sum = pre_en ? a + d : a;            // wraps to A_W bits
    m       = M_W'(pre_sum) * M_W'(b);
    prod    = {{(P_W-M_W){m[M_W-1]}}, m};
  end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_slice_pkg::*;
(
  input  logic [P_W-1:0]   x,
  input  logic [P_W-1:0]   z,
  input  aluop_e           op,
  input  simd_e            simd,
  input  logic [3:0]       fn,
  output logic [P_W-1:0]   res,
  output logic [N_SEG-1:0] co
);
  addres_t ar;
  always_comb begin
    ar = lane_addsub(z, x, op == OP_SUB, simd);
    if (op == OP_LOGIC) begin
      res = logic_unit(x, z, fn);
      co  = '0;
    end else begin
      res = ar.sum;
      co  = ar.co;
    end
  end
endmodule

// File: rtl/mac_patdet.sv
module mac_patdet #(
  parameter int           W       = 48,
  parameter logic [W-1:0] PATTERN = '0,
  parameter logic [W-1:0] MASK    = '1
) (
  input  logic [W-1:0] val,
  output logic         hit,
  output logic         hit_inv
);
  localparam logic [W-1:0] PAT_N = ~PATTERN;
  assign hit     = ((val ^ PATTERN) & MASK) == '0;
  assign hit_inv = ((val ^ PAT_N) & MASK) == '0;
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int         A_W     = 25,
  parameter int         B_W     = 18,
  parameter bit         IN_REG  = 1'b1,
  parameter bit         MUL_REG = 1'b1,
  parameter logic [47:0] PATTERN = 48'h0,
  parameter logic [47:0] MASK    = 48'hFFFF_FFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic signed [24:0]  a_in,
  input  logic signed [24:0]  d_in,
  input  logic signed [17:0]  b_in,
  input  logic [47:0]         ab_in,
  input  logic [47:0]         c_in,
  input  logic                pre_en,
  input  logic                mul_bypass,
  input  logic [1:0]          z_sel,
  input  logic [1:0]          alu_op,
  input  logic [1:0]          simd_mode,
  input  logic [3:0]          logic_fn,
  output logic [47:0]         p_out,
  output logic [3:0]          carry_out,
  output logic                pat_hit,
  output logic                pat_hit_inv
);
  localparam int CT_W = $bits(ctrl_t);
  localparam int AC_W = $bits(alu_ctrl_t);
  localparam int S1_W = 2*A_W + B_W + 2*P_W + CT_W;
  localparam int S2_W = 2*P_W + AC_W;

  // stage 1: operands and opcodes
  ctrl_t ctrl_in, ctrl1;
  always_comb begin
    ctrl_in.pre_en     = pre_en;
    ctrl_in.mul_bypass = mul_bypass;
    ctrl_in.alu.zsel   = zsel_e'(z_sel);
    ctrl_in.alu.op     = aluop_e'(alu_op);
    ctrl_in.alu.simd   = simd_e'(simd_mode);
    ctrl_in.alu.fn     = logic_fn;
  end

  logic [S1_W-1:0] s1_q;
  logic signed [A_W-1:0] a1, d1;
  logic signed [B_W-1:0] b1;
  logic [P_W-1:0] ab1, c1;

  mac_stage_reg #(.W(S1_W), .EN(IN_REG)) u_in_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .d({a_in, d_in, b_in, ab_in, c_in, ctrl_in}), .q(s1_q));
  assign {a1, d1, b1, ab1, c1, ctrl1} = s1_q;

  // multiplier and X operand choice
  logic [P_W-1:0] prod1, x1;
  mac_mult #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mult (
    .a(a1), .d(d1), .b(b1), .pre_en(ctrl1.pre_en), .prod(prod1));
  assign x1 = ctrl1.mul_bypass ? ab1 : prod1;

  // stage 2: X, C and ALU opcodes
  logic [S2_W-1:0] s2_q;
  logic [P_W-1:0]  x2, c2;
  alu_ctrl_t       actl2;
  mac_stage_reg #(.W(S2_W), .EN(MUL_REG)) u_mul_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d({x1, c1, ctrl1.alu}), .q(s2_q));
  assign {x2, c2, actl2} = s2_q;

  // Z operand, fed back from the result register
  logic [P_W-1:0] p_q;
  logic [P_W-1:0] z2;
  always_comb begin
    case (actl2.zsel)
      Z_ACC:   z2 = p_q;
      Z_C:     z2 = c2;
      default: z2 = '0;
    endcase
  end

  logic [P_W-1:0]   alu_res;
  logic [N_SEG-1:0] alu_co;
  mac_alu u_alu (
    .x(x2), .z(z2), .op(actl2.op), .simd(actl2.simd), .fn(actl2.fn),
    .res(alu_res), .co(alu_co));

  logic det_hit, det_hit_inv;
  mac_patdet #(.W(P_W), .PATTERN(PATTERN), .MASK(MASK)) u_patdet (
    .val(alu_res), .hit(det_hit), .hit_inv(det_hit_inv));

  // output / accumulator register
  logic [N_SEG-1:0] co_q;
  logic             hit_q, hit_inv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q       <= '0;
      co_q      <= '0;
      hit_q     <= 1'b0;
      hit_inv_q <= 1'b0;
    end else if (ce) begin
      p_q       <= alu_res;
      co_q      <= alu_co;
      hit_q     <= det_hit;
      hit_inv_q <= det_hit_inv;
    end
  end

  assign p_out       = p_q;
  assign carry_out   = co_q;
  assign pat_hit     = hit_q;
  assign pat_hit_inv = hit_inv_q;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
  import mac_slice_pkg::*;
#(
  parameter logic [47:0] MASK = 48'hFFFF_FFFF_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input zsel_e       zsel,
  input aluop_e      op,
  input simd_e       simd,
  input logic [47:0] x_op,
  input logic [47:0] p_out,
  input logic [3:0]  carry_out,
  input logic        pat_hit,
  input logic        pat_hit_inv
);
  p_one_lane_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && op != OP_LOGIC && (simd == SIMD_ONE || simd == SIMD_RSV)) |=> carry_out[3:1] == 3'b000);

  p_two_lane_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && op != OP_LOGIC && simd == SIMD_TWO) |=> carry_out[3:2] == 2'b00);

  p_logic_no_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && op == OP_LOGIC) |=> carry_out == 4'b0000);

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(p_out) && $stable(carry_out) && $stable(pat_hit) && $stable(pat_hit_inv)));

  p_count_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && zsel == Z_ACC && op == OP_ADD && simd == SIMD_ONE && x_op == 48'd1)
      |=> p_out == $past(p_out) + 48'd1);

  p_count_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && zsel == Z_ACC && op == OP_SUB && simd == SIMD_ONE && x_op == 48'd1)
      |=> p_out == $past(p_out) - 48'd1);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (MASK != 48'h0) |-> !(pat_hit && pat_hit_inv));
endmodule

bind mac_slice mac_slice_chk #(.MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce),
  .zsel(actl2.zsel), .op(actl2.op), .simd(actl2.simd), .x_op(x2),
  .p_out(p_out), .carry_out(carry_out), .pat_hit(pat_hit), .pat_hit_inv(pat_hit_inv));

// File: tb/mac_slice_tb_top.sv
module mac_slice_tb_top;
  localparam bit          IN_R  = 1'b1;
  localparam bit          MUL_R = 1'b1;
  localparam int          DEPTH = IN_R + MUL_R;
  localparam logic [47:0] PAT   = 48'h0;
  localparam logic [47:0] MSK   = 48'h0000_0000_0FFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic               rst_n, ce;
  logic signed [24:0] a_in, d_in;
  logic signed [17:0] b_in;
  logic [47:0]        ab_in, c_in;
  logic               pre_en, mul_bypass;
  logic [1:0]         z_sel, alu_op, simd_mode;
  logic [3:0]         logic_fn;
  logic [47:0]        p_out;
  logic [3:0]         carry_out;
  logic               pat_hit, pat_hit_inv;

  mac_slice #(.IN_REG(IN_R), .MUL_REG(MUL_R), .PATTERN(PAT), .MASK(MSK)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .d_in(d_in), .b_in(b_in),
    .ab_in(ab_in), .c_in(c_in), .pre_en(pre_en), .mul_bypass(mul_bypass),
    .z_sel(z_sel), .alu_op(alu_op), .simd_mode(simd_mode), .logic_fn(logic_fn),
    .p_out(p_out), .carry_out(carry_out), .pat_hit(pat_hit), .pat_hit_inv(pat_hit_inv));

  typedef struct {
    longint      a, d, b;
    logic [47:0] ab, c;
    bit          pre, byp;
    int          zs, op, sm, fn;
  } rec_t;

  rec_t        pend[$];
  logic [47:0] m_acc;
  logic [3:0]  m_co;
  bit          m_hit, m_hinv;
  int          n_cmp = 0, n_bad = 0;
  string       req = "R1";
  bit          done = 1'b0;

  function automatic rec_t zero_rec();
    rec_t r;
    r.a = 0; r.d = 0; r.b = 0; r.ab = '0; r.c = '0;
    r.pre = 0; r.byp = 0; r.zs = 0; r.op = 0; r.sm = 0; r.fn = 0;
    return r;
  endfunction

  // Model of one ALU-stage evaluation written from the requirements
  task automatic model_apply(rec_t r);
    longint      pa, prod;
    logic [47:0] x, z, res;
    logic [63:0] zl, xl, s, msk;
    int          lanes, w;
    logic [3:0]  co;
    pa = r.a + (r.pre ? r.d : 0);
    if (pa > 16777215)  pa -= 33554432;
    if (pa < -16777216) pa += 33554432;
    prod = pa * r.b;
    x = r.byp ? r.ab : prod[47:0];
    case (r.zs)
      1: z = m_acc;
      2: z = r.c;
      default: z = '0;
    endcase
    co = '0;
    res = '0;
    if (r.op == 2) begin
      case (r.fn)
        0: res = x & z;       1: res = x | z;
        2: res = x ^ z;       3: res = ~(x ^ z);
        4: res = ~(x & z);    5: res = ~(x | z);
        6: res = x & ~z;      7: res = ~x & z;
        8: res = x | ~z;      9: res = ~x | z;
        default: res = '0;
      endcase
    end else begin
      lanes = (r.sm == 1) ? 2 : (r.sm == 2) ? 4 : 1;
      w = 48 / lanes;
      msk = (64'd1 << w) - 64'd1;
      for (int l = 0; l < lanes; l++) begin
        zl = ({16'h0, z} >> (l*w)) & msk;
        xl = ({16'h0, x} >> (l*w)) & msk;
        if (r.op == 1) s = zl + ((~xl) & msk) + 64'd1;
        else           s = zl + xl;
        res = res | 48'((s & msk) << (l*w));
        co[l] = s[w];
      end
    end
    m_acc  = res;
    m_co   = co;
    m_hit  = ((res ^ PAT) & MSK) == 48'h0;
    m_hinv = ((res ^ ~PAT) & MSK) == 48'h0;
  endtask

  task automatic compare();
    n_cmp++;
    if (p_out !== m_acc || carry_out !== m_co || pat_hit !== m_hit || pat_hit_inv !== m_hinv) begin
      n_bad++;
      $display("FAIL %s: got p=%h co=%b hit=%b inv=%b, expected p=%h co=%b hit=%b inv=%b",
               req, p_out, carry_out, pat_hit, pat_hit_inv, m_acc, m_co, m_hit, m_hinv);
    end
  endtask

  task automatic tick();
    rec_t r;
    @(posedge clk);
    if (ce && rst_n) begin
      r.a = a_in; r.d = d_in; r.b = b_in; r.ab = ab_in; r.c = c_in;
      r.pre = pre_en; r.byp = mul_bypass; r.zs = z_sel; r.op = alu_op;
      r.sm = simd_mode; r.fn = logic_fn;
      pend.push_back(r);
      if (pend.size() > DEPTH) model_apply(pend.pop_front());
    end
    @(negedge clk);
    compare();
  endtask

  task automatic set_op(bit pre, bit byp, int zs, int op, int sm, int fn);
    pre_en = pre; mul_bypass = byp; z_sel = 2'(zs); alu_op = 2'(op);
    simd_mode = 2'(sm); logic_fn = 4'(fn);
  endtask

  task automatic mul(longint a, longint d, longint b);
    a_in = 25'(a); d_in = 25'(d); b_in = 18'(b);
  endtask

  task automatic drain();
    set_op(0, 1, 1, 0, 0, 0);
    ab_in = '0;
    repeat (DEPTH + 1) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1;
    mul(0, 0, 0); ab_in = '0; c_in = '0;
    set_op(0, 0, 0, 0, 0, 0);
    m_acc = '0; m_co = '0; m_hit = 0; m_hinv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1"; compare();                       // reset state
    for (int i = 0; i < DEPTH; i++) pend.push_back(zero_rec());
    rst_n = 1'b1;

    // R2 plain signed products
    req = "R2";
    set_op(0, 0, 0, 0, 0, 0);
    mul(1234, 0, -77);                  tick();
    mul(-16777216, 0, -131072);         tick();
    mul(16777215, 0, 131071);           tick();
    mul(-5, 0, 3);                      tick();
    drain();

    // R3 pre-adder, including wrap past the 25-bit range
    req = "R3";
    set_op(1, 0, 0, 0, 0, 0);
    mul(16777215, 1, 3);                tick();
    mul(-16777216, -1, 2);              tick();
    mul(100, -250, -9);                 tick();
    drain();

    // R4/R5 bypass with Z choices and subtraction
    req = "R4";
    c_in = 48'h1234_5678_9ABC;
    set_op(0, 1, 2, 0, 0, 0); ab_in = 48'h0000_FFFF_0001; tick();
    req = "R5";
    set_op(0, 1, 2, 1, 0, 0); ab_in = 48'h2222_0000_FFFF; tick();
    set_op(0, 1, 3, 0, 0, 0); ab_in = 48'h00AB_CDEF_0000; tick();
    set_op(0, 1, 0, 1, 0, 0); ab_in = 48'h1;              tick();
    drain();

    // R6 accumulate products
    req = "R6";
    set_op(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      mul(1000 * (i + 1) - 3000, 0, -(i * 17) + 40); tick();
    end
    set_op(0, 0, 1, 1, 0, 0); mul(-7777, 0, 123); tick();
    drain();

    // R7 lane splits, changing every cycle while feeding back
    req = "R7";
    c_in = 48'hFFFF_FFFF_FFFF; ab_in = 48'h0010_0100_1001;
    for (int sm = 0; sm < 4; sm++) begin
      set_op(0, 1, 2, 0, sm, 0); tick();
      set_op(0, 1, 2, 1, sm, 0); tick();
    end
    for (int i = 0; i < 8; i++) begin
      set_op(0, 1, 1, i % 2, (i + 1) % 3, 0);
      ab_in = 48'h8FF8_FF8F_F8FF;
      tick();
    end
    drain();

    // R8 logic functions over all codes
    req = "R8";
    c_in = 48'hF0F0_CCCC_AAAA;
    ab_in = 48'hFF00_F0F0_6666;
    for (int f = 0; f < 16; f++) begin
      set_op(0, 1, 2, 2, f % 3, f); tick();
    end
    drain();

    // R9/R11 counter crossing the pattern windows
    req = "R9";
    c_in = 48'h0000_0000_0FFD;
    set_op(0, 1, 2, 0, 0, 0); ab_in = 48'h0; tick();
    req = "R11";
    set_op(0, 1, 1, 0, 0, 0); ab_in = 48'h1;
    repeat (6) tick();
    set_op(0, 1, 1, 1, 0, 0);
    repeat (8) tick();

    // R10 clock enable freeze mid-stream
    req = "R10";
    set_op(0, 0, 1, 0, 0, 0); mul(321, 0, 45); tick();
    ce = 1'b0;
    set_op(0, 1, 2, 2, 0, 5); ab_in = 48'hDEAD_BEEF_0000;
    repeat (4) tick();
    ce = 1'b1;
    mul(-9, 0, 11); set_op(0, 0, 1, 0, 0, 0); tick();
    drain();

    // mixed traffic touching every requirement
    req = "R5";
    for (int i = 0; i < 300; i++) begin
      ce = ($urandom % 8) != 0;
      mul($signed(25'($urandom)), $signed(25'($urandom)), $signed(18'($urandom)));
      ab_in = {16'($urandom), 32'($urandom)};
      c_in  = {16'($urandom), 32'($urandom)};
      set_op($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 16);
      tick();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule